// File: doc/BRIEF.md
# Clocked Serial Shift Port

An eight-bit synchronous serial port that can act as clock master or clock slave. Software loads the outgoing byte as two four-bit halves over a small register bus. It picks the clock role and the sampling edge, then sets a start bit. As master, the port divides the system clock and drives the serial clock out. As slave, it takes the serial clock from a pin, passes it through a two-flop synchronizer and detects its edges in the system clock domain.

One shift register serves both directions. Bit 0 goes out first on the data output, and that output moves only on rising serial clock edges. Incoming data is sampled on the rising or the falling edge, as software chooses, and enters at the top of the register. After the eighth rising edge the transfer ends and the received byte can be read back through the same two halves. A completion flag is then set, and an interrupt request follows the flag only when its enable bit is 1. In slave mode a ready output tells the external master that the port is armed.

Register map (`bus_addr`): 0 = data bits 3..0; 1 = data bits 7..4; 2 = control (bit 0 start on write / busy on read, bit 1 edge select, bit 2 master, bit 3 reads 0); 3 = status (bit 0 completion flag, bit 1 interrupt enable).

Top module: `sync_shift_port`

## Requirements
- R1: After reset every register reads 0, `irq`, `ready` and `sclk_oe` are 0 and `sclk_out` is 1.
- R2: While idle, writes to address 0 set data bits 3..0 and writes to address 1 set bits 7..4, and each half reads back unchanged.
- R3: A write to address 2 with bit 0 set starts a transfer using bit 1 (edge select) and bit 2 (master) from the same write, and address 2 bit 0 reads 1 from then until completion.
- R4: In master mode `sclk_oe` is 1 and `sclk_out` idles high; during a transfer it toggles every HALF_DIV system clocks, giving eight low-then-high cycles.
- R5: `sout` shows data bit 0 right after the start and changes only on rising serial clock edges, showing bit k after the k-th rising edge for k = 1..7.
- R6: With edge select 1, `sin` is sampled on rising serial clock edges; with edge select 0, on falling edges. The first sampled bit ends in bit 0 of the received byte.
- R7: The transfer ends on the eighth rising edge. Busy then clears, status bit 0 becomes 1 and addresses 0 and 1 return the received byte.
- R8: The completion flag is set whether or not the interrupt is enabled, and `irq` equals the flag ANDed with status bit 1.
- R9: Writing address 3 with bit 0 = 1 clears the flag, writing bit 0 = 0 leaves it, and a completion in the same cycle wins over the clear.
- R10: In slave mode the external serial clock passes through two synchronizing flip-flops, so `sout` responds on the third system clock edge after a rising `sclk_in`, and `ready` is 1 exactly while a slave transfer is armed.
- R11: During a transfer, writes to addresses 0, 1 and 2 (including a new start) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Register read data for `bus_addr` |
| sclk_in | input | 1 | Serial clock from an external master |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for `sclk_out` (master mode) |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| ready | output | 1 | Slave port armed and waiting for clocks |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a serial clock edge never arrives in the same system cycle as its opposite edge. They also assume that, in slave mode, the external clock holds each level for at least three system clocks, so the synchronizer sees every edge. The bench drives the slave clock with half periods of eight system clocks and idles it high. It changes `sin` only on the edge opposite the sampling edge, so data never moves near a sample point. Master transfers are paced by the design itself, and bench writes during a transfer take place only between serial edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int NIB_W  = 4;
  localparam int DATA_W = 2 * NIB_W;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef enum logic [ADDR_W-1:0] {
    A_DLO  = 2'd0,
    A_DHI  = 2'd1,
    A_CTRL = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic busy,
  input  logic start,
  input  logic sclk_in,
  output logic sclk_out,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic             sclk_q, sclk_d;
  logic             sync1_q, sync2_q, prev_q;
  logic             tick;

  // master: divider and clock register
  always_comb begin
    tick   = master && busy && (div_q == DIV_W'(HALF_DIV - 1));
    div_d  = div_q;
    sclk_d = sclk_q;
    if (start) begin
      div_d = '0;
    end else if (master && busy) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  // slave: two-flop synchronizer plus edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= sclk_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    if (master) begin
      ev_rise = tick && !sclk_q;
      ev_fall = tick &&  sclk_q;
    end else begin
      ev_rise =  sync2_q && !prev_q;
      ev_fall = !sync2_q &&  prev_q;
    end
  end

  assign sclk_out = sclk_q;

  AST_MASTER_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> sclk_q) else $error("idle master clock low"); // R4
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [NIB_W-1:0] wdata,
  input  logic             edge_sel,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic             sin,
  output logic             busy,
  output logic             sout,
  output logic [DATA_W-1:0] data,
  output logic             xfer_done
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              sout_q, sout_d;
  logic              sr_en;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted   = {sin, sr_q[DATA_W-1:1]};
    sr_d      = sr_q;
    cnt_d     = cnt_q;
    busy_d    = busy_q;
    sout_d    = sout_q;
    xfer_done = 1'b0;
    if (!busy_q) begin
      if (wr_lo) sr_d[NIB_W-1:0]      = wdata;
      if (wr_hi) sr_d[DATA_W-1:NIB_W] = wdata;
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        sout_d = sr_q[0];
      end
    end else begin
      if (ev_fall && !edge_sel) sr_d = shifted;
      if (ev_rise) begin
        if (edge_sel) sr_d = shifted;
        sout_d = edge_sel ? sr_q[1] : sr_q[0];
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DATA_W - 1)) begin
          busy_d    = 1'b0;
          xfer_done = 1'b1;
        end
      end
    end
    sr_en = (sr_d != sr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      if (sr_en) sr_q <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      sout_q <= sout_d;
    end
  end

  assign busy = busy_q;
  assign sout = sout_q;
  assign data = sr_q;

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rise && ev_fall)) else $error("both edges at once"); // R6
  AST_SR_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ev_rise && !ev_fall) |=> $stable(sr_q)) else $error("data moved off edge"); // R11
  AST_SOUT_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ev_rise) |=> $stable(sout_q)) else $error("sout moved off rising edge"); // R5
  AST_END_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(ev_rise)) else $error("end without rising edge"); // R7
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] data,
  input  logic              xfer_done,
  output logic              start,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              edge_sel,
  output logic              master,
  output logic              irq
);
  logic edge_q, master_q, flag_q, ien_q;
  logic ctrl_en, stat_wr, flag_d;

  always_comb begin
    wr_lo   = bus_wr && (bus_addr == A_DLO)  && !busy;
    wr_hi   = bus_wr && (bus_addr == A_DHI)  && !busy;
    ctrl_en = bus_wr && (bus_addr == A_CTRL) && !busy;
    stat_wr = bus_wr && (bus_addr == A_STAT);
    start   = ctrl_en && bus_wdata[0];
    flag_d  = flag_q;
    if (stat_wr && bus_wdata[0]) flag_d = 1'b0;
    if (xfer_done)               flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q   <= 1'b0;
      master_q <= 1'b0;
      flag_q   <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (ctrl_en) begin
        edge_q   <= bus_wdata[1];
        master_q <= bus_wdata[2];
      end
      if (stat_wr) ien_q <= bus_wdata[1];
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DLO:   bus_rdata = data[NIB_W-1:0];
      A_DHI:   bus_rdata = data[DATA_W-1:NIB_W];
      A_CTRL:  bus_rdata = {1'b0, master_q, edge_q, busy};
      default: bus_rdata = {2'b00, ien_q, flag_q};
    endcase
  end

  assign edge_sel = edge_q;
  assign master   = master_q;
  assign irq      = flag_q && ien_q;

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> flag_q) else $error("flag not set"); // R8
  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(stat_wr && bus_wdata[0])) else $error("flag lost"); // R9
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sin,
  output logic              sout,
  output logic              ready,
  output logic              irq
);
  logic rst_m_q, rst_s_q;
  logic start, wr_lo, wr_hi, edge_sel, master, busy;
  logic ev_rise, ev_fall, xfer_done;
  logic [DATA_W-1:0] data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  ssp_regs u_regs (
    .clk(clk), .rst_n(rst_s_q), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .data(data),
    .xfer_done(xfer_done), .start(start), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .edge_sel(edge_sel), .master(master), .irq(irq)
  );

  ssp_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_s_q), .master(master), .busy(busy), .start(start),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  ssp_shifter u_shift (
    .clk(clk), .rst_n(rst_s_q), .start(start), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .edge_sel(edge_sel), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .sin(sin), .busy(busy), .sout(sout), .data(data), .xfer_done(xfer_done)
  );

  assign sclk_oe = master;
  assign ready   = busy && !master;
endmodule

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;
  localparam int HALF_DIV = 2;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [3:0] bus_wdata = 4'd0;
  logic [3:0] bus_rdata;
  logic       sclk_in = 1'b1;
  logic       sclk_out, sclk_oe, sout, ready, irq;
  logic       sin_b = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sync_shift_port #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sin(sin_b), .sout(sout),
    .ready(ready), .irq(irq)
  );

  function automatic logic exp_irq(input logic flag, input logic ien);
    return flag & ien;
  endfunction

  function automatic logic exp_sout(input logic [7:0] tx, input int k);
    return tx[k];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [3:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic run_xfer(input bit master, input bit edge_s, input logic [7:0] tx,
                          input logic [7:0] rx, input bit ien, input bit poke);
    logic [3:0] rd;
    int idx, rises, gap, guard;
    logic prev;
    idx = 0;
    bus_write(2'd3, {2'b00, ien, 1'b0});
    bus_write(2'd0, tx[3:0]);
    bus_write(2'd1, tx[7:4]);
    bus_read(2'd0, rd); check("R2 low half", rd, tx[3:0]);
    bus_read(2'd1, rd); check("R2 high half", rd, tx[7:4]);
    sin_b = rx[0];
    bus_write(2'd2, {1'b0, master, edge_s, 1'b1});
    bus_read(2'd2, rd); check("R3 busy after start", rd[0], 1'b1);
    check("R5 bit0 first", sout, exp_sout(tx, 0));
    check("R4 clock enable", sclk_oe, master);
    if (master) begin
      rises = 0; gap = 0; guard = 0; prev = sclk_out;
      while (rises < 8 && guard < 1000) begin
        @(negedge clk);
        gap++; guard++;
        if (sclk_out !== prev) begin
          check("R4 half period", gap, HALF_DIV);
          gap = 0;
          if (sclk_out) begin
            rises++;
            if (rises < 8) check("R5 sout after rise", sout, exp_sout(tx, rises));
          end else begin
            check("R5 sout held on fall", sout, exp_sout(tx, rises));
          end
          if (sclk_out == edge_s) idx++;
          else if (idx < 8) sin_b = rx[idx];
          check("R10 ready low as master", ready, 1'b0);
          prev = sclk_out;
        end
      end
      check("R4 eight cycles", rises, 8);
    end else begin
      for (int k = 1; k <= 8; k++) begin
        sclk_in = 1'b0;
        if (edge_s == 1'b0) idx++;
        else if (idx < 8) sin_b = rx[idx];
        if (poke && k == 4) begin
          bus_write(2'd0, ~tx[3:0]);
          bus_write(2'd1, ~tx[7:4]);
          bus_write(2'd2, {1'b0, 1'b1, ~edge_s, 1'b1});
          repeat (H - 3) @(negedge clk);
        end else begin
          repeat (H) @(negedge clk);
        end
        check("R5 sout held on fall", sout, exp_sout(tx, k - 1));
        check("R10 ready while armed", ready, 1'b1);
        sclk_in = 1'b1;
        if (edge_s == 1'b1) idx++;
        else if (idx < 8) sin_b = rx[idx];
        repeat (2) @(negedge clk);
        check("R10 sync delay", sout, exp_sout(tx, k - 1));
        repeat (H - 2) @(negedge clk);
        if (k < 8) check("R5 sout after rise", sout, exp_sout(tx, k));
      end
    end
    repeat (4) @(negedge clk);
    bus_read(2'd2, rd);
    check("R3 busy cleared", rd[0], 1'b0);
    check("R11 control kept", rd[2:1], {master, edge_s});
    check("R10 ready low after", ready, 1'b0);
    check("R4 idle high", sclk_out, 1'b1);
    bus_read(2'd3, rd);
    check("R7 flag set", rd[0], 1'b1);
    check("R8 irq follows enable", irq, exp_irq(1'b1, ien));
    bus_read(2'd0, rd); check("R6 R7 received low", rd, rx[3:0]);
    bus_read(2'd1, rd); check("R6 R7 received high", rd, rx[7:4]);
    bus_write(2'd3, {2'b00, ien, 1'b0});
    bus_read(2'd3, rd); check("R9 zero write keeps flag", rd[0], 1'b1);
    bus_write(2'd3, {2'b00, ien, 1'b1});
    bus_read(2'd3, rd); check("R9 one write clears flag", rd[0], 1'b0);
    check("R8 irq drops with flag", irq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], rd);
      check("R1 register reset", rd, 4'h0);
    end
    check("R1 irq reset", irq, 1'b0);
    check("R1 ready reset", ready, 1'b0);
    check("R1 clock enable reset", sclk_oe, 1'b0);
    check("R1 clock idle", sclk_out, 1'b1);

    run_xfer(1'b1, 1'b1, 8'hA5, 8'h3C, 1'b1, 1'b0);
    run_xfer(1'b1, 1'b0, 8'h01, 8'h80, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b1, 8'h96, 8'hF0, 1'b1, 1'b0);
    run_xfer(1'b0, 1'b0, 8'h5A, 8'h0F, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b1, 8'hC3, 8'h69, 1'b1, 1'b1);   // R11 writes mid transfer
    run_xfer(1'b0, 1'b0, 8'h3E, 8'hB2, 1'b0, 1'b1);   // R11 writes mid transfer
    run_xfer(1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0);
    run_xfer(1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b0);

    for (int n = 0; n < 12; n++) begin
      run_xfer(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
               1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule